// File: doc/BRIEF.md
# System management and control interrupt generator

This block gathers platform events and produces two interrupt signals for the processor. The first is an active-low management interrupt line, `smi_n_o`. Any incoming management event pulls it low, and it stays low until software acknowledges it with an end-of-handler strobe. The line then rests high for a fixed recovery window. Any event that arrived while the line was busy or resting is held, and it drives the line low again as soon as the window closes.

The second output is a level-mode control interrupt. It is built from a set of sticky source status bits, each gated by its own enable bit. That level is steered to one of seven physical interrupt lines, chosen by a routing number. The three low numbers may always be used. Four higher numbers are legal only when the advanced interrupt controller mode is selected. The sharing flag sets the polarity on every line: a line that is shared with PCI interrupts is active-low, and an unshared line is active-high.

Top module: `sysint_gen`

## Requirements
- R1: When the management line is idle and any bit of `smi_evt_i` is high at a clock edge, `smi_n_o` is low from that edge on.
- R2: Once low, `smi_n_o` stays low until `eos_wr_i` is sampled high. A pulse on `eos_wr_i` while `smi_n_o` is high has no effect on any output.
- R3: The edge that samples `eos_wr_i` drives `smi_n_o` high, and it then stays high for GAP_CYC (default 4) cycles without exception.
- R4: Events sampled while the line is low or inside the recovery window set `smi_pend_o`. A pending event pulls `smi_n_o` low on the edge that ends the window, so the line is high for exactly GAP_CYC cycles. The same edge clears `smi_pend_o`.
- R5: The control level is high while any bit of `sci_sts_o & sci_en_i` is set. It stays high until every enabled status bit has been cleared.
- R6: A high `sci_set_i[k]` sets `sci_sts_o[k]`, and a high `sci_clr_i[k]` clears it (write-one-to-clear). When both are high in the same cycle, the set wins.
- R7: Output line index j carries interrupt number 9+j for j=0..2 and 17+j for j=3..6. Routing numbers 9, 10 and 11 are always legal. Numbers 20 to 23 are legal only when `apic_mode_i` is high.
- R8: A routing number that is not legal in the current mode keeps every line of `sci_irq_o` at its inactive level.
- R9: When `shared_i` is high, lines are active-low; otherwise they are active-high. Every line that is not selected is driven to the inactive level.
- R10: After reset, `smi_n_o` is high, `smi_pend_o` is low and every status bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_evt_i | input | N_SMI | Management event pulses |
| eos_wr_i | input | 1 | End-of-handler write strobe |
| sci_set_i | input | N_SCI | Control source status set pulses |
| sci_clr_i | input | N_SCI | Write-one-to-clear for status bits |
| sci_en_i | input | N_SCI | Control source enables |
| apic_mode_i | input | 1 | Selects the advanced interrupt controller routing set |
| irq_sel_i | input | 5 | Routing interrupt number |
| shared_i | input | 1 | Selected line is shared with PCI interrupts (active-low) |
| smi_n_o | output | 1 | Management interrupt, active low |
| sci_irq_o | output | 7 | Per-line control interrupt outputs |
| smi_pend_o | output | 1 | A management event is waiting |
| sci_sts_o | output | N_SCI | Control source status bits |

## Verification
Three collisions are the main targets. The first is a new event and the acknowledge strobe in the same cycle. The second is an event landing in the last cycle of the recovery window, which decides between reasserting the line and going idle. The third is a status bit receiving a set and a clear at once. The bench drives each of these on purpose, with the event placed on the exact strobe or window-end cycle. A behavioural model compares the line level, the pending flag, the status bits and every interrupt line on every clock. It also sweeps all 32 routing numbers under both modes and both polarities.

// File: rtl/sysint_pkg.sv
package sysint_pkg;

    localparam int N_LINES = 7;

    typedef enum logic [1:0] {
        SMI_IDLE   = 2'd0,
        SMI_ACTIVE = 2'd1,
        SMI_GAP    = 2'd2
    } smi_state_e;

    typedef struct packed {
        logic       level;
        logic       legal;
        logic       shared;
        logic [4:0] sel;
    } route_req_t;

    function automatic logic [4:0] line_irq(input int j);
        return (j < 3) ? 5'(9 + j) : 5'(17 + j);
    endfunction

    function automatic logic sel_legal(input logic [4:0] sel, input logic apic);
        return ((sel >= 5'd9) && (sel <= 5'd11)) ||
               (apic && (sel >= 5'd20) && (sel <= 5'd23));
    endfunction

endpackage

// File: rtl/smi_ctl.sv
module smi_ctl
    import sysint_pkg::*;
#(
    parameter int N_SMI   = 8,
    parameter int GAP_CYC = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SMI-1:0] evt_i,
    input  logic             eos_i,
    output logic             smi_n_o,
    output logic             pend_o
);
    localparam int CW = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

    smi_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          any_evt;

    assign any_evt = |evt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SMI_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SMI_IDLE: begin
                    if (any_evt) state_q <= SMI_ACTIVE;
                end
                SMI_ACTIVE: begin
                    if (any_evt) pend_q <= 1'b1;
                    if (eos_i) begin
                        state_q <= SMI_GAP;
                        cnt_q   <= '0;
                    end
                end
                SMI_GAP: begin
                    if (cnt_q == LAST) begin
                        if (pend_q || any_evt) begin
                            state_q <= SMI_ACTIVE;
                            pend_q  <= 1'b0;
                        end else begin
                            state_q <= SMI_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (any_evt) pend_q <= 1'b1;
                    end
                end
                default: state_q <= SMI_IDLE;
            endcase
        end
    end

    assign smi_n_o = (state_q != SMI_ACTIVE);
    assign pend_o  = pend_q;

    // Checker state: length of the current high run, saturating at GAP_CYC
    localparam int HW = $clog2(GAP_CYC + 1);
    logic [HW-1:0] hi_run;
    logic          was_active;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run     <= '0;
            was_active <= 1'b0;
        end else if (!smi_n_o) begin
            hi_run     <= '0;
            was_active <= 1'b1;
        end else if (hi_run != HW'(GAP_CYC)) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    assert_evt_pulls_low_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == SMI_IDLE && any_evt) |=> !smi_n_o);

    assert_hold_until_eos_R2: assert property (@(posedge clk) disable iff (rst)
        (!smi_n_o && !eos_i) |=> !smi_n_o);

    assert_min_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (was_active && !smi_n_o && hi_run != '0) |-> (hi_run == HW'(GAP_CYC)));

    assert_pend_reasserts_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SMI_GAP && cnt_q == LAST && pend_q) |=> (!smi_n_o && !pend_o));

endmodule

// File: rtl/sci_status.sv
module sci_status #(
    parameter int N_SCI = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SCI-1:0] set_i,
    input  logic [N_SCI-1:0] clr_i,
    input  logic [N_SCI-1:0] en_i,
    output logic [N_SCI-1:0] sts_o,
    output logic             level_o
);
    logic [N_SCI-1:0] sts_q;

    for (genvar k = 0; k < N_SCI; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           sts_q[k] <= 1'b0;
            else if (set_i[k]) sts_q[k] <= 1'b1;
            else if (clr_i[k]) sts_q[k] <= 1'b0;
        end
    end

    assign sts_o   = sts_q;
    assign level_o = |(sts_q & en_i);

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_o & $past(clr_i & ~set_i)) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/sci_router.sv
module sci_router
    import sysint_pkg::*;
(
    input  route_req_t         req_i,
    output logic [N_LINES-1:0] irq_o
);
    logic [N_LINES-1:0] hit;

    for (genvar j = 0; j < N_LINES; j++) begin : g_line
        assign hit[j]   = req_i.level && req_i.legal && (req_i.sel == line_irq(j));
        assign irq_o[j] = hit[j] ^ req_i.shared;
    end

    always_comb begin
        assert_one_line_R7: assert ($onehot0(irq_o ^ {N_LINES{req_i.shared}}));
        if (!req_i.legal)
            assert_illegal_quiet_R8: assert (irq_o == {N_LINES{req_i.shared}});
    end

endmodule

// File: rtl/sysint_gen.sv
module sysint_gen
    import sysint_pkg::*;
#(
    parameter int N_SMI   = 8,
    parameter int N_SCI   = 8,
    parameter int GAP_CYC = 4
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SMI-1:0]   smi_evt_i,
    input  logic               eos_wr_i,
    input  logic [N_SCI-1:0]   sci_set_i,
    input  logic [N_SCI-1:0]   sci_clr_i,
    input  logic [N_SCI-1:0]   sci_en_i,
    input  logic               apic_mode_i,
    input  logic [4:0]         irq_sel_i,
    input  logic               shared_i,
    output logic               smi_n_o,
    output logic [N_LINES-1:0] sci_irq_o,
    output logic               smi_pend_o,
    output logic [N_SCI-1:0]   sci_sts_o
);
    logic       sci_level;
    route_req_t rreq;

    smi_ctl #(.N_SMI(N_SMI), .GAP_CYC(GAP_CYC)) u_smi (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (smi_evt_i),
        .eos_i  (eos_wr_i),
        .smi_n_o(smi_n_o),
        .pend_o (smi_pend_o)
    );

    sci_status #(.N_SCI(N_SCI)) u_sts (
        .clk    (clk),
        .rst    (rst),
        .set_i  (sci_set_i),
        .clr_i  (sci_clr_i),
        .en_i   (sci_en_i),
        .sts_o  (sci_sts_o),
        .level_o(sci_level)
    );

    always_comb begin
        rreq.level  = sci_level;
        rreq.legal  = sel_legal(irq_sel_i, apic_mode_i);
        rreq.shared = shared_i;
        rreq.sel    = irq_sel_i;
    end

    sci_router u_route (
        .req_i(rreq),
        .irq_o(sci_irq_o)
    );

    assert_level_follows_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(sci_sts_o & sci_en_i) != '0 && $past(sci_clr_i) == '0 &&
         $stable(sci_en_i) && $stable(irq_sel_i) && $stable(apic_mode_i) &&
         $stable(shared_i) && sel_legal(irq_sel_i, apic_mode_i))
        |-> (sci_irq_o != {N_LINES{shared_i}}));

    assert_reset_state_R10: assert property (@(posedge clk)
        $past(rst) |-> (smi_n_o && !smi_pend_o && sci_sts_o == '0));

endmodule

// File: tb/sysint_gen_bench.sv
module sysint_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NC = 8;
    localparam int GAP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] smi_evt = '0;
    logic          eos_wr = 1'b0;
    logic [NC-1:0] sci_set = '0, sci_clr = '0, sci_en = '0;
    logic          apic = 1'b0, shared = 1'b0;
    logic [4:0]    sel = 5'd9;
    logic          smi_n, smi_pend;
    logic [6:0]    sci_irq;
    logic [NC-1:0] sci_sts;

    int checks = 0, errors = 0;
    string req = "R10";

    // reference model state
    int            m_state = 0;   // 0 idle, 1 active, 2 gap
    int            m_cnt = 0;
    bit            m_pend = 0;
    logic [NC-1:0] m_sts = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysint_gen #(.N_SMI(NS), .N_SCI(NC), .GAP_CYC(GAP)) u_sysint_gen (
        .clk(clk), .rst(rst), .smi_evt_i(smi_evt), .eos_wr_i(eos_wr),
        .sci_set_i(sci_set), .sci_clr_i(sci_clr), .sci_en_i(sci_en),
        .apic_mode_i(apic), .irq_sel_i(sel), .shared_i(shared),
        .smi_n_o(smi_n), .sci_irq_o(sci_irq), .smi_pend_o(smi_pend),
        .sci_sts_o(sci_sts)
    );

    task automatic model_edge();
        bit ev = (smi_evt != 0);
        if (rst) begin
            m_state = 0; m_cnt = 0; m_pend = 0; m_sts = '0;
            return;
        end
        m_sts = (m_sts & ~sci_clr) | sci_set;
        case (m_state)
            0: if (ev) m_state = 1;
            1: begin
                if (ev) m_pend = 1;
                if (eos_wr) begin m_state = 2; m_cnt = 0; end
            end
            default: begin
                if (m_cnt == GAP - 1) begin
                    if (m_pend || ev) begin m_state = 1; m_pend = 0; end
                    else m_state = 0;
                end else begin
                    m_cnt++;
                    if (ev) m_pend = 1;
                end
            end
        endcase
    endtask

    function automatic logic [6:0] exp_irq();
        logic [6:0] r;
        bit lvl = ((m_sts & sci_en) != 0);
        bit ok = (sel >= 9 && sel <= 11) || (apic && sel >= 20 && sel <= 23);
        for (int j = 0; j < 7; j++) begin
            int num = (j < 3) ? 9 + j : 17 + j;
            r[j] = (lvl && ok && sel == num) ^ shared;
        end
        return r;
    endfunction

    task automatic compare();
        logic [6:0] ei = exp_irq();
        checks++;
        if (smi_n !== (m_state != 1)) begin
            errors++; $display("FAIL %s smi_n got %b exp %b", req, smi_n, m_state != 1);
        end
        if (smi_pend !== m_pend) begin
            errors++; $display("FAIL %s smi_pend got %b exp %b", req, smi_pend, m_pend);
        end
        if (sci_sts !== m_sts) begin
            errors++; $display("FAIL %s sci_sts got %h exp %h", req, sci_sts, m_sts);
        end
        if (sci_irq !== ei) begin
            errors++; $display("FAIL %s sci_irq got %b exp %b", req, sci_irq, ei);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic idle_inputs();
        smi_evt = '0; eos_wr = 0; sci_set = '0; sci_clr = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        req = "R10";
        step(); step();
        rst = 0;
        step();

        // R2: EOS while idle has no effect
        req = "R2";
        eos_wr = 1; step(); idle_inputs(); step(); step();

        // R1: single event pulls line low
        req = "R1";
        smi_evt = 8'h04; step(); idle_inputs();
        req = "R2";
        for (int i = 0; i < 6; i++) step();

        // R3: acknowledge, no pending -> gap then idle
        req = "R3";
        eos_wr = 1; step(); idle_inputs();
        for (int i = 0; i < GAP + 2; i++) step();

        // R4: event during active and same cycle as EOS
        req = "R4";
        smi_evt = 8'h01; step(); idle_inputs();
        step();
        smi_evt = 8'h80; eos_wr = 1; step(); idle_inputs();
        for (int i = 0; i < GAP + 2; i++) step();
        eos_wr = 1; step(); idle_inputs();
        // event inside gap
        step();
        smi_evt = 8'h10; step(); idle_inputs();
        for (int i = 0; i < GAP + 1; i++) step();
        eos_wr = 1; step(); idle_inputs();
        // event in final gap cycle
        for (int i = 0; i < GAP - 1; i++) step();
        smi_evt = 8'h02; step(); idle_inputs();
        step(); step();
        eos_wr = 1; step(); idle_inputs();
        for (int i = 0; i < GAP + 2; i++) step();
        // R2: EOS during gap ignored
        req = "R2";
        smi_evt = 8'h01; step(); idle_inputs();
        eos_wr = 1; step(); step(); idle_inputs();
        for (int i = 0; i < GAP + 2; i++) step();

        // R6 and R5: status set, enable, clear
        req = "R6";
        sel = 5'd10; apic = 0; shared = 0;
        sci_set = 8'h05; step(); idle_inputs(); step();
        req = "R5";
        sci_en = 8'h04; step();
        sci_en = 8'h05; step();
        sci_clr = 8'h04; step(); idle_inputs(); step();
        sci_clr = 8'h01; step(); idle_inputs(); step();
        req = "R6";
        sci_set = 8'h20; sci_clr = 8'h20; sci_en = 8'h20; step(); idle_inputs(); step();

        // R7, R8, R9: full routing sweep with level high
        for (int a = 0; a < 2; a++)
            for (int s = 0; s < 2; s++)
                for (int n = 0; n < 32; n++) begin
                    apic = a[0]; shared = s[0]; sel = 5'(n);
                    req = s ? "R9" : ((n >= 9 && n <= 11) || (n >= 20 && n <= 23)) ? "R7" : "R8";
                    step();
                end
        // R9: level low, every line inactive
        req = "R9";
        sci_clr = 8'hff; step(); idle_inputs();
        apic = 1; sel = 5'd22; shared = 1; step();
        shared = 0; step();

        // R10: reset mid-activity
        req = "R10";
        smi_evt = 8'h01; sci_set = 8'h03; step(); idle_inputs();
        smi_evt = 8'h01; step(); idle_inputs();
        rst = 1; step(); rst = 0; step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule